// File: doc/BRIEF.md
# Piecewise Linear Exponential Unit

This unit produces a fixed-point approximation of e^x by splitting a bounded input domain into equal-width segments and evaluating a straight line per segment. Each segment owns a slope and an intercept held in a small register table that is loaded through a write port. An accepted input is clamped to the domain, its segment is found with a shift instead of a division, that segment's coefficients are read, and the result is slope times input plus intercept, saturated into the output format.

The unit sits in front of a softmax normaliser, which sums and divides its outputs. Software picks the accuracy by choosing the segment width (a power of two) and by loading matching coefficients. The input stream carries a valid/ready handshake. The output is a valid-qualified word with a fixed latency and no backpressure.

Top module: `pwl_exp_unit`

## Requirements
- R1: With an input x (signed, 32 bits, 26 fraction bits) and the selected segment's slope s and intercept b (both signed, 32 bits, 5 fraction bits), out_data_o (signed, 32 bits, 5 fraction bits) equals floor(s*x) + b in output LSBs. This is within one LSB of the real-valued s*x + b.
- R2: The segment index is floor((x + 16) / h) with h = 2^SEG_LOG2. At the default h = 1 there are 32 segments, and index 0 covers [-16, -15). An input exactly on a breakpoint belongs to the upper segment.
- R3: An input below -16 is evaluated as -16 on segment 0. An input at or above +16 is evaluated as the largest value below +16 (raw 0x3FFFFFFF) on the last segment.
- R4: An input accepted at a rising edge gives out_valid_o high after the second following rising edge. One input is accepted per cycle while in_ready_o is high.
- R5: When cfg_we_i is high, the slope and intercept are written to entry cfg_addr_i at the rising edge. In that cycle in_ready_o is low, and an offered input is not accepted and produces no output.
- R6: An accepted input uses the coefficients present when it was accepted. A write to its segment in the next cycle does not change its result.
- R7: A result above 0x7FFFFFFF becomes 0x7FFFFFFF, and a result below 0x80000000 becomes 0x80000000.
- R8: After reset, out_valid_o is 0, out_data_o is 0 and every table entry is zero, so any input yields 0.
- R9: While out_valid_o is low, out_data_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Input word can be taken this cycle |
| in_data_i | input | 32 | Signed input, 26 fraction bits |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | 32 | Signed result, 5 fraction bits |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | IDX_W (5) | Segment entry written |
| cfg_slope_i | input | 32 | Slope, signed, 5 fraction bits |
| cfg_icpt_i | input | 32 | Intercept, signed, 5 fraction bits |

## Verification
A coefficient write and an input offer can land in the same cycle, and so can a write and an input already in flight. The bench drives both cases on purpose. In the first, a write and a valid input go together. The bench checks that in_ready_o drops, that no result appears two cycles later, and that the written values are used for the next input. In the second, an input is accepted and its own segment is rewritten one cycle later. The bench judges the result against the old coefficients, and then against the new ones for a fresh input.

// File: rtl/pwl_exp_pkg.sv
package pwl_exp_pkg;

  localparam int COEF_W = 32;

  typedef struct packed {
    logic signed [COEF_W-1:0] slope;
    logic signed [COEF_W-1:0] icpt;
  } coef_t;

endpackage

// File: rtl/pwl_seg_index.sv
module pwl_seg_index #(
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 26,
  parameter int DOM_LOG2 = 4,
  parameter int SEG_LOG2 = 0,
  parameter int IDX_W    = 5
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic        [IDX_W-1:0] idx_o,
  output logic signed [IN_W-1:0]  xc_o
);

  localparam int BW      = IN_W + 2;
  localparam int EDGE_SH = DOM_LOG2 + IN_FRAC;
  localparam int SHIFT   = IN_FRAC + SEG_LOG2;

  localparam logic signed [BW-1:0] OFFS  = BW'(1) << EDGE_SH;
  localparam logic signed [BW-1:0] LIMIT = BW'(1) << (EDGE_SH + 1);

  logic signed [BW-1:0] biased;
  assign biased = BW'(x_i) + OFFS;

  generate
    if (EDGE_SH >= IN_W - 1) begin : g_noclamp
      // domain covers the whole input range
      assign idx_o = IDX_W'(biased >>> SHIFT);
      assign xc_o  = x_i;
    end else begin : g_clamp
      localparam logic signed [IN_W-1:0] X_HI = IN_W'((BW'(1) << EDGE_SH) - BW'(1));
      localparam logic signed [IN_W-1:0] X_LO = ~X_HI;
      localparam logic [IDX_W-1:0]       IDX_LAST = '1;

      always_comb begin
        if (biased[BW-1]) begin
          idx_o = '0;
          xc_o  = X_LO;
        end else if (biased >= LIMIT) begin
          idx_o = IDX_LAST;
          xc_o  = X_HI;
        end else begin
          idx_o = IDX_W'(biased >>> SHIFT);
          xc_o  = x_i;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pwl_coef_table.sv
module pwl_coef_table import pwl_exp_pkg::*; #(
  parameter int IDX_W = 5,
  parameter int NSEG  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  coef_t            wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output coef_t            rdata_o
);

  coef_t ent_q [NSEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSEG; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];

endmodule

// File: rtl/pwl_mac.sv
module pwl_mac import pwl_exp_pkg::*; #(
  parameter int IN_W    = 32,
  parameter int IN_FRAC = 26
) (
  input  logic signed [IN_W-1:0]   x_i,
  input  coef_t                    coef_i,
  output logic signed [COEF_W-1:0] y_o
);

  localparam int PROD_W = IN_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;

  localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

  logic signed [PROD_W-1:0] x_ext, s_ext, prod, prod_sh;
  logic signed [SUM_W-1:0]  sum;

  assign x_ext   = PROD_W'(x_i);
  assign s_ext   = PROD_W'(coef_i.slope);
  assign prod    = x_ext * s_ext;
  // coefficients share the output fraction, so drop the input fraction
  assign prod_sh = prod >>> IN_FRAC;
  assign sum     = SUM_W'(prod_sh) + SUM_W'(coef_i.icpt);

  always_comb begin
    if (sum > MAXV)      y_o = MAXV[COEF_W-1:0];
    else if (sum < MINV) y_o = MINV[COEF_W-1:0];
    else                 y_o = sum[COEF_W-1:0];
  end

endmodule

// File: rtl/pwl_exp_unit.sv
module pwl_exp_unit import pwl_exp_pkg::*; #(
  parameter  int IN_W     = 32,
  parameter  int IN_FRAC  = 26,
  parameter  int DOM_LOG2 = 4,
  parameter  int SEG_LOG2 = 0,
  localparam int IDX_W    = DOM_LOG2 + 1 - SEG_LOG2,
  localparam int NSEG     = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_data_i,
  output logic              out_valid_o,
  output logic [COEF_W-1:0] out_data_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [COEF_W-1:0] cfg_slope_i,
  input  logic [COEF_W-1:0] cfg_icpt_i
);

  logic                     acc;
  logic [IDX_W-1:0]         seg_idx;
  logic signed [IN_W-1:0]   xc;
  coef_t                    rd_coef, wr_coef;
  logic                     s1_vld;
  logic signed [IN_W-1:0]   s1_x;
  coef_t                    s1_coef;
  logic signed [COEF_W-1:0] mac_res;

  // table has one port: a write takes it and stalls input
  assign in_ready_o = !cfg_we_i;
  assign acc        = in_valid_i && in_ready_o;

  assign wr_coef.slope = cfg_slope_i;
  assign wr_coef.icpt  = cfg_icpt_i;

  pwl_seg_index #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .DOM_LOG2(DOM_LOG2),
    .SEG_LOG2(SEG_LOG2), .IDX_W(IDX_W)
  ) u_idx (
    .x_i   (in_data_i),
    .idx_o (seg_idx),
    .xc_o  (xc)
  );

  pwl_coef_table #(.IDX_W(IDX_W), .NSEG(NSEG)) u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (wr_coef),
    .raddr_i (seg_idx),
    .rdata_o (rd_coef)
  );

  pwl_mac #(.IN_W(IN_W), .IN_FRAC(IN_FRAC)) u_mac (
    .x_i    (s1_x),
    .coef_i (s1_coef),
    .y_o    (mac_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld      <= 1'b0;
      s1_x        <= '0;
      s1_coef     <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      s1_vld <= acc;
      if (acc) begin
        s1_x    <= xc;
        s1_coef <= rd_coef;
      end
      out_valid_o <= s1_vld;
      if (s1_vld) out_data_o <= mac_res;
    end
  end

endmodule

// File: rtl/pwl_exp_unit_chk.sv
module pwl_exp_unit_chk import pwl_exp_pkg::*; #(
  parameter int IN_W  = 32,
  parameter int IDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_i,
  input logic [IN_W-1:0]   in_data_i,
  input logic              out_valid_i,
  input logic [COEF_W-1:0] out_data_i,
  input logic [IDX_W-1:0]  seg_idx_i,
  input logic              s1_vld_i,
  input coef_t             s1_coef_i
);

  localparam logic [IN_W-1:0]  X_MIN = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [IN_W-1:0]  X_MAX = ~X_MIN;
  localparam logic [IDX_W-1:0] LAST  = '1;

  logic acc;
  assign acc = in_valid_i && in_ready_i;

  a_r4_two_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> ##2 out_valid_i);

  a_r4_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> $past(acc, 2));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_i |-> $stable(out_data_i));

  a_r1_flat_segment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_i && s1_coef_i.slope == '0) |=> ($signed(out_data_i) == $past(s1_coef_i.icpt)));

  a_r3_low_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_data_i == X_MIN) |-> seg_idx_i == '0);

  a_r3_high_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_data_i == X_MAX) |-> seg_idx_i == LAST);

endmodule

bind pwl_exp_unit pwl_exp_unit_chk #(.IN_W(IN_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_i  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o),
  .seg_idx_i   (seg_idx),
  .s1_vld_i    (s1_vld),
  .s1_coef_i   (s1_coef)
);

// File: tb/pwl_exp_unit_tb.sv
module pwl_exp_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG       = 32;
  localparam int NV         = 16;
  localparam real H         = 1.0;
  localparam real X_HI_R    = 1073741823.0 / 67108864.0;

  localparam logic [31:0] VEC_X [NV] = '{
    32'hC000_0000, 32'h8000_0000, 32'hBFFF_FFFF, 32'h7FFF_FFFF,
    32'h4000_0000, 32'h3FFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF,
    32'h0400_0000, 32'h03FF_FFFF, 32'hFE00_0000, 32'h0D00_0000,
    32'hD800_0000, 32'h2A00_0000, 32'h3C00_0000, 32'hC000_0001
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_slope = '0;
  logic [31:0] cfg_icpt = '0;

  int n_chk = 0;
  int n_fail = 0;
  int tb_slope [NSEG];
  int tb_icpt  [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwl_exp_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_slope_i(cfg_slope), .cfg_icpt_i(cfg_icpt)
  );

  function automatic real x_clamped(logic [31:0] x);
    real r = $itor($signed(x)) / 67108864.0;
    if (r < -16.0) r = -16.0;
    if (r > X_HI_R) r = X_HI_R;
    return r;
  endfunction

  function automatic int seg_of(logic [31:0] x);
    int s = $rtoi($floor((x_clamped(x) + 16.0) / H));
    if (s < 0) s = 0;
    if (s > NSEG - 1) s = NSEG - 1;
    return s;
  endfunction

  function automatic real model(int s, int b, logic [31:0] x);
    real e = $itor(s) * x_clamped(x) + $itor(b);
    if (e > 2147483647.0) e = 2147483647.0;
    if (e < -2147483648.0) e = -2147483648.0;
    return e;
  endfunction

  function automatic int to_int(real v);
    if (v > 2147483000.0) v = 2147483000.0;
    if (v < -2147483000.0) v = -2147483000.0;
    return int'(v);
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_near(string tag, logic [31:0] act, real exp);
    real d = $itor($signed(act)) - exp;
    n_chk++;
    if (d > 1.0 || d < -1.0) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0f", tag, $signed(act), exp);
    end
  endtask

  task automatic write_coef(int idx, int s, int b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_slope = s; cfg_icpt = b;
    tb_slope[idx] = s; tb_icpt[idx] = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_one(logic [31:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R4 act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int old_s, old_b, s;

    // R8 reset state
    repeat (3) @(negedge clk);
    check_eq("R8 valid in reset", {31'b0, out_valid}, 32'd0);
    check_eq("R8 data in reset", out_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R5 ready idle", {31'b0, in_ready}, 32'd1);
    send_one(32'h0D00_0000);
    check_eq("R8 valid after empty-table input", {31'b0, out_valid}, 32'd1);
    check_eq("R8 cleared table gives zero", out_data, 32'd0);

    // load exp chords, offset intercepts so neighbours differ at breakpoints
    for (int i = 0; i < NSEG; i++) begin
      real x0 = -16.0 + $itor(i) * H;
      real e0 = $exp(x0);
      real m  = ($exp(x0 + H) - e0) / H;
      real b  = e0 - m * x0;
      write_coef(i, to_int(m * 32.0), to_int(b * 32.0) + i * 50);
    end

    // R1 R2 R3 R4 streamed vectors, one per cycle
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        s = seg_of(VEC_X[i-2]);
        check_eq("R4 valid two cycles after accept", {31'b0, out_valid}, 32'd1);
        check_near("R1 R2 R3 segment result", out_data,
                   model(tb_slope[s], tb_icpt[s], VEC_X[i-2]));
      end
      if (i < NV) begin
        check_eq("R4 ready every cycle", {31'b0, in_ready}, 32'd1);
        in_valid = 1'b1; in_data = VEC_X[i];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R9 hold while idle
    held = out_data;
    repeat (3) @(negedge clk);
    check_eq("R9 valid low when idle", {31'b0, out_valid}, 32'd0);
    check_eq("R9 data held", out_data, held);

    // R5 write and offered input in the same cycle
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h0D00_0000;
    cfg_we = 1'b1; cfg_addr = 5'd19; cfg_slope = 32'd640; cfg_icpt = 32'd1234;
    tb_slope[19] = 640; tb_icpt[19] = 1234;
    #1;
    check_eq("R5 ready low during write", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check_eq("R5 blocked input gives no result", {31'b0, out_valid}, 32'd0);
    send_one(32'h0D00_0000);
    check_near("R5 written coefficients used", out_data,
               model(640, 1234, 32'h0D00_0000));

    // R6 rewrite of an in-flight segment
    old_s = tb_slope[23]; old_b = tb_icpt[23];
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h1C00_0000;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'd23; cfg_slope = 32'd96; cfg_icpt = 32'd77;
    tb_slope[23] = 96; tb_icpt[23] = 77;
    @(negedge clk);
    cfg_we = 1'b0;
    check_eq("R6 in-flight valid", {31'b0, out_valid}, 32'd1);
    check_near("R6 in-flight keeps old coefficients", out_data,
               model(old_s, old_b, 32'h1C00_0000));
    send_one(32'h1C00_0000);
    check_near("R6 later input sees new coefficients", out_data,
               model(96, 77, 32'h1C00_0000));

    // R7 saturation both ways
    write_coef(31, 32'h7FFF_FFFF, 32'h7FFF_FF00);
    send_one(32'h7FFF_FFFF);
    check_eq("R7 positive saturation", out_data, 32'h7FFF_FFFF);
    write_coef(0, 32'h7FFF_FFFF, 0);
    send_one(32'h8000_0000);
    check_eq("R7 negative saturation", out_data, 32'h8000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule